// File: doc/BRIEF.md
# Frame-Triggered Microcode Sequencer

This block supplies instructions to a small dedicated signal processor. It reads 16-bit instruction words from a code memory that is shared with other masters. In each frame of the sampling multiplexer it runs through the program exactly once. The program is relocatable: an 8-bit location value picks a 1 KB-aligned region of the code memory. That gives a start word address of 512 times the location value, which is the same as a byte address of 1024 times the value.

When a frame-start strobe arrives, the sequencer captures the location value and restarts its offset at zero. It then requests one word at a time and waits for the arbiter's grant before it moves on. Each ordinary word is handed to the execution datapath with a one-cycle valid pulse. The halt word `16'hFFFF` ends the pass, and the sequencer then stays idle until the next frame start.

Two conditions are counted as an overrun: the frame ending before the halt has been reached, and the program running past its 4096-word limit. Either one sets a sticky flag that software clears.

Top module: `ucode_pass_seq`

## Requirements
- R1: While reset is active and just after it, `memReq`, `instrValid` and `overrun` are all low.
- R2: A `frameStart` pulse captures `locReg`. From the next cycle on, `memReq` is high and `memAddr` equals `locReg` times 512 (word address).
- R3: A request advances `memAddr` by exactly one word per cycle in which `memGnt` is high. In a cycle without a grant, the address and the instruction stream both hold, and no word is skipped or repeated.
- R4: A granted word other than `16'hFFFF` appears on `instrOut`, with `instrValid` high for one cycle, in the cycle after the grant.
- R5: A granted word equal to `16'hFFFF` is never output. `memReq` drops in the next cycle and stays low, with no valid pulse, until the next `frameStart`. A halt at offset 0 yields no instructions.
- R6: A `frameEnd` pulse during a pass aborts it. The word granted in that cycle is discarded, `memReq` drops and `overrun` rises in the next cycle. A `frameEnd` pulse while idle has no effect.
- R7: `overrun` stays high until `ovfClr` is pulsed. When a new overrun and `ovfClr` happen in the same cycle, the flag stays set.
- R8: If 4096 words are emitted without a halt, the word at offset 4095 is still output. After that the sequencer stops requesting and sets `overrun`, rather than wrapping.
- R9: A change of `locReg` during a pass does not alter that pass's addresses. It takes effect at the next `frameStart`.
- R10: A `frameStart` during a pass restarts fetching at the newly captured base without emitting the word granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Multiplexer frame begins (one-cycle strobe) |
| frameEnd | input | 1 | Multiplexer frame ends (one-cycle strobe) |
| locReg | input | 8 | Program location, in 1 KB units |
| ovfClr | input | 1 | Clears the overrun flag |
| memReq | output | 1 | Code memory read request |
| memAddr | output | 18 | Code memory word address |
| memGnt | input | 1 | Grant from the shared-memory arbiter; `memData` is valid in this cycle |
| memData | input | 16 | Code memory read data |
| instrOut | output | 16 | Instruction word to the datapath |
| instrValid | output | 1 | `instrOut` is valid for this cycle |
| overrun | output | 1 | Sticky flag: pass not completed in time |

## Verification
A wrong offset or base register appears directly at the ports. The bench's memory returns an address-dependent word, so a skipped, repeated or misplaced fetch turns up as a wrong `instrOut` at the very next valid pulse. A run state that fails to leave the pass leaves `memReq` high after a halt or a frame end, and this is visible one cycle later. A lost or spurious overrun condition shows on `overrun` in the cycle after the triggering strobe, and it stays there until the flag is cleared.

// File: rtl/ucseq_pkg.sv
`timescale 1ns/1ps
package ucseq_pkg;

  // Strobes from the control FSM to the fetch datapath
  typedef struct packed {
    logic loadBase;  // capture location register
    logic clrOfs;    // restart offset at zero
    logic incOfs;    // step offset by one word
    logic emit;      // register the granted word as an instruction
  } seqStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

endpackage

// File: rtl/seq_datapath.sv
`timescale 1ns/1ps
module seq_datapath
  import ucseq_pkg::*;
#(
  parameter int LOC_W     = 8,
  parameter int OFS_W     = 12,
  parameter int WORD_W    = 16,
  parameter int BLK_SHIFT = 9,
  parameter int ADDR_W    = LOC_W + BLK_SHIFT + 1,
  parameter logic [WORD_W-1:0] HALT_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strb,
  input  logic [LOC_W-1:0]  locReg,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              isHalt,
  output logic              ofsLast,
  output logic [WORD_W-1:0] instrOut,
  output logic              instrValid
);

  logic [LOC_W-1:0]  baseLoc;
  logic [OFS_W-1:0]  ofs;
  logic [WORD_W-1:0] instrQ;
  logic              validQ;

  // base and offset registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseLoc <= '0;
      ofs     <= '0;
    end else begin
      if (strb.loadBase) baseLoc <= locReg;
      if (strb.clrOfs)      ofs <= '0;
      else if (strb.incOfs) ofs <= ofs + 1'b1;
    end
  end

  // instruction output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instrQ <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.emit;
      if (strb.emit) instrQ <= memData;
    end
  end

  assign memAddr    = ADDR_W'({baseLoc, {BLK_SHIFT{1'b0}}}) + ADDR_W'(ofs);
  assign isHalt     = (memData == HALT_WORD);
  assign ofsLast    = &ofs;
  assign instrOut   = instrQ;
  assign instrValid = validQ;

  AST_VALID_NOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    instrValid |-> (instrOut != HALT_WORD)); // R5

endmodule

// File: rtl/seq_control.sv
`timescale 1ns/1ps
module seq_control
  import ucseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       ovfClr,
  input  logic       memGnt,
  input  logic       isHalt,
  input  logic       ofsLast,
  output seqStrobe_t strb,
  output logic       memReq,
  output logic       overrun
);

  seqState_t state, stateNxt;
  logic      ovfQ;
  logic      running, granted, halting, endAbort, emitNow, exhaust;

  assign running  = (state == SEQ_RUN);
  assign granted  = running && memGnt;
  // a halt granted in the same cycle as frame end still completes the pass
  assign endAbort = running && frameEnd && !(granted && isHalt);
  assign halting  = granted && isHalt && !frameStart;
  assign emitNow  = granted && !isHalt && !frameEnd && !frameStart;
  assign exhaust  = emitNow && ofsLast;

  always_comb begin
    stateNxt = state;
    if (frameStart)                        stateNxt = SEQ_RUN;
    else if (endAbort || halting || exhaust) stateNxt = SEQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      ovfQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (endAbort || exhaust) ovfQ <= 1'b1;
      else if (ovfClr)         ovfQ <= 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadBase = frameStart;
    strb.clrOfs   = frameStart;
    strb.incOfs   = emitNow;
    strb.emit     = emitNow;
  end

  assign memReq  = running;
  assign overrun = ovfQ;

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> memReq); // R2
  AST_STOP_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && frameEnd && !frameStart) |=> !memReq); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovfClr) |=> overrun); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!memReq && !frameStart) |=> !memReq); // R5

endmodule

// File: rtl/ucode_pass_seq.sv
`timescale 1ns/1ps
module ucode_pass_seq
  import ucseq_pkg::*;
#(
  parameter int LOC_W     = 8,
  parameter int OFS_W     = 12,
  parameter int WORD_W    = 16,
  parameter int BLK_SHIFT = 9,
  parameter logic [WORD_W-1:0] HALT_WORD = '1,
  localparam int ADDR_W   = LOC_W + BLK_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic [LOC_W-1:0]  locReg,
  input  logic              ovfClr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  input  logic [WORD_W-1:0] memData,
  output logic [WORD_W-1:0] instrOut,
  output logic              instrValid,
  output logic              overrun
);

  seqStrobe_t strb;
  logic       isHalt;
  logic       ofsLast;

  seq_control i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .ovfClr     (ovfClr),
    .memGnt     (memGnt),
    .isHalt     (isHalt),
    .ofsLast    (ofsLast),
    .strb       (strb),
    .memReq     (memReq),
    .overrun    (overrun)
  );

  seq_datapath #(
    .LOC_W     (LOC_W),
    .OFS_W     (OFS_W),
    .WORD_W    (WORD_W),
    .BLK_SHIFT (BLK_SHIFT),
    .ADDR_W    (ADDR_W),
    .HALT_WORD (HALT_WORD)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .locReg     (locReg),
    .memData    (memData),
    .memAddr    (memAddr),
    .isHalt     (isHalt),
    .ofsLast    (ofsLast),
    .instrOut   (instrOut),
    .instrValid (instrValid)
  );

  AST_BASE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> (memAddr == ADDR_W'({$past(locReg), {BLK_SHIFT{1'b0}}}))); // R2
  AST_HOLD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memGnt && !frameStart) |=> $stable(memAddr)); // R3
  AST_VALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    instrValid |-> $past(memReq && memGnt)); // R4

endmodule

// File: tb/test_ucode_pass_seq.sv
`timescale 1ns/1ps
module test_ucode_pass_seq;

  localparam int LOC_W  = 8;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 18;
  localparam int NWORDS = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameStart = 1'b0, frameEnd = 1'b0, ovfClr = 1'b0;
  logic [LOC_W-1:0] locReg = '0;
  logic memReq, memGnt, instrValid, overrun;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memData, instrOut;

  logic gntRand = 1'b0;
  logic gntMask = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  logic haltOn = 1'b0;
  logic [ADDR_W-1:0] haltAddr = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [WORD_W-1:0] expQ[$];

  always #2.5 clk = ~clk;

  ucode_pass_seq i_ucode_pass_seq (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .frameEnd(frameEnd),
    .locReg(locReg), .ovfClr(ovfClr), .memReq(memReq), .memAddr(memAddr),
    .memGnt(memGnt), .memData(memData), .instrOut(instrOut),
    .instrValid(instrValid), .overrun(overrun)
  );

  function automatic logic [WORD_W-1:0] wordAt(input logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    w = a[WORD_W-1:0] ^ 16'h3C00;
    if (w == 16'hFFFF) w = 16'h0001;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] baseOf(input logic [LOC_W-1:0] loc);
    return ADDR_W'(loc) << 9;
  endfunction

  // code memory model
  always_comb begin
    if (haltOn && memAddr == haltAddr) memData = 16'hFFFF;
    else                               memData = wordAt(memAddr);
  end
  assign memGnt = memReq & gntMask;

  always @(negedge clk) begin
    lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    gntMask = gntRand ? lfsr[0] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && instrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "unexpected instruction", instrOut, 0);
      end else begin
        logic [WORD_W-1:0] e;
        e = expQ.pop_front();
        check(instrOut == e, "R4", "instruction word (R3 order)", instrOut, e);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "WDOG", "watchdog expired", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pushWords(input logic [LOC_W-1:0] loc, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(wordAt(baseOf(loc) + ADDR_W'(i)));
  endtask

  task automatic startFrame(input logic [LOC_W-1:0] loc);
    locReg = loc;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    check(memReq == 1'b1, "R2", "request after start", memReq, 1);
    check(memAddr == baseOf(loc), "R2", "first address", memAddr, baseOf(loc));
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (memReq && n < 6000) begin
      @(negedge clk);
      n++;
    end
    check(n < 6000, req, "pass did not stop", n, 6000);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, req, "words left in scoreboard", expQ.size(), 0);
  endtask

  task automatic clearOvf();
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    check(overrun == 1'b0, "R7", "flag cleared", overrun, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(memReq == 1'b0, "R1", "memReq in reset", memReq, 0);
    check(instrValid == 1'b0, "R1", "instrValid in reset", instrValid, 0);
    check(overrun == 1'b0, "R1", "overrun in reset", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(memReq == 1'b0 && overrun == 1'b0, "R1", "idle after reset", memReq, 0);

    // R4/R5: plain pass, halt at offset 6, full grants
    haltOn = 1'b1; haltAddr = baseOf(8'd2) + 18'd6;
    pushWords(8'd2, 6);
    startFrame(8'd2);
    waitIdle("R5");
    check(overrun == 1'b0, "R5", "no overrun on halt", overrun, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!memReq && !instrValid, "R5", "quiet after halt", {memReq, instrValid}, 0);
    end

    // R3: random grants
    gntRand = 1'b1;
    haltAddr = baseOf(8'd3) + 18'd20;
    pushWords(8'd3, 20);
    startFrame(8'd3);
    waitIdle("R3");

    // R5: halt at offset 0
    haltAddr = baseOf(8'd9);
    startFrame(8'd9);
    waitIdle("R5");

    // R9: location change mid-pass ignored
    haltAddr = baseOf(8'd5) + 18'd15;
    pushWords(8'd5, 15);
    startFrame(8'd5);
    repeat (3) @(negedge clk);
    locReg = 8'd7;
    waitIdle("R9");
    haltAddr = baseOf(8'd7) + 18'd3;
    pushWords(8'd7, 3);
    startFrame(8'd7);
    waitIdle("R9");
    gntRand = 1'b0;
    @(negedge clk);

    // R6: frame end during pass, 10 words granted before it
    haltAddr = baseOf(8'd4) + 18'd3000;
    pushWords(8'd4, 10);
    startFrame(8'd4);
    repeat (10) @(negedge clk);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    check(overrun == 1'b1, "R6", "overrun on frame end", overrun, 1);
    check(memReq == 1'b0, "R6", "request dropped", memReq, 0);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R6", "words left", expQ.size(), 0);

    // R7: sticky, then clear
    repeat (5) @(negedge clk);
    check(overrun == 1'b1, "R7", "flag held", overrun, 1);
    clearOvf();

    // R6: frame end while idle
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    @(negedge clk);
    check(overrun == 1'b0, "R6", "idle frame end ignored", overrun, 0);

    // R7: set wins over clear
    startFrame(8'd4);
    frameEnd = 1'b1; ovfClr = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0; ovfClr = 1'b0;
    check(overrun == 1'b1, "R7", "set beats clear", overrun, 1);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R7", "no words emitted", expQ.size(), 0);
    clearOvf();

    // R10: restart mid-pass at a new base
    haltAddr = baseOf(8'd6) + 18'd4;
    pushWords(8'd4, 5);
    pushWords(8'd6, 4);
    startFrame(8'd4);
    repeat (5) @(negedge clk);
    startFrame(8'd6);
    waitIdle("R10");
    check(overrun == 1'b0, "R10", "restart is not overrun", overrun, 0);

    // R8: run past the end of the program space
    haltOn = 1'b0;
    pushWords(8'd3, NWORDS);
    startFrame(8'd3);
    waitIdle("R8");
    check(overrun == 1'b1, "R8", "overrun on exhaustion", overrun, 1);
    clearOvf();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule